// File: doc/BRIEF.md
# Serial Port Interrupt Status Unit

This block gathers the four interrupt sources of a synchronous serial port and turns them into one interrupt line. Two sources are receive errors: a receive overrun and a receive timeout. They arrive as single-cycle pulses and are held in status flags until software clears them. The other two sources are FIFO service requests: receive FIFO half full and transmit FIFO half empty. They are levels, and the status follows them directly. Software cannot clear them.

A small register port gives access to four locations, chosen by a 2-bit address. Address 0 is the enable mask (read/write). Address 1 is the raw status (read only). Address 2 is the masked status (read only). Address 3 is the clear register (write only; it reads as zero). Reads are combinational from the address. Writes take effect at the clock edge where the write strobe is high. The interrupt output is the registered OR of the masked status.

Top module: `spi_irq_status`

## Requirements
- R1: After reset, the mask is 0000, both error flags are 0 and `irq_o` is 0.
- R2: Status bit positions are fixed: bit 0 is receive overrun, bit 1 is receive timeout, bit 2 is receive FIFO service and bit 3 is transmit FIFO service. The raw status at address 1 shows every source whatever its mask bit.
- R3: The masked status at address 2 equals the raw status ANDed with the mask.
- R4: A source whose mask bit is 0 never drives `irq_o` high. With a mask of 0000, `irq_o` stays 0.
- R5: `irq_o` is registered. One clock after the masked status changes, it equals the OR of the masked status bits.
- R6: An overrun or timeout pulse sets its flag at the next clock edge. The flag then stays set until it is cleared.
- R7: Writing a one to bit 0 or bit 1 of address 3 clears the matching error flag. Zero bits in that write have no effect.
- R8: If a set pulse and a clear of the same flag occur in the same cycle, the flag ends up set.
- R9: A write to address 0 loads all four mask bits. A read-modify-write that changes one bit leaves the other three bits unchanged.
- R10: Writes to addresses 1 and 2 change nothing. Address 3 reads as 0000.
- R11: Bits 2 and 3 follow their service inputs in the same cycle and are not latched. Writing ones to bits 2 and 3 of address 3 does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_svc_i | input | 1 | Transmit FIFO half-empty level |
| rx_svc_i | input | 1 | Receive FIFO half-full level |
| rx_tmo_pulse_i | input | 1 | Receive timeout event pulse |
| rx_ovr_pulse_i | input | 1 | Receive overrun event pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 mask, 1 raw, 2 masked, 3 clear) |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Register read data, combinational from address |
| irq_o | output | 1 | Interrupt request |

## Verification
Each result has its own due time:
- An error pulse shows in the raw and masked status right after the clock edge that samples it.
- A change on a service level shows in the status read in the same cycle, with no clock edge needed.
- `irq_o` lags the masked status by exactly one more edge.
- A mask or clear write shows on the read port just after its edge.

The bench drives and samples 2 ns after each rising edge. It reads the status before it advances the clock, then checks `irq_o` one edge later. The sweep covers all 16 masks against all 16 source patterns.

// File: rtl/spi_irq_status.sv
module spi_irq_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_svc_i,
  input  logic       rx_svc_i,
  input  logic       rx_tmo_pulse_i,
  input  logic       rx_ovr_pulse_i,
  input  logic       reg_we_i,
  input  logic [1:0] reg_addr_i,
  input  logic [3:0] reg_wdata_i,
  output logic [3:0] reg_rdata_o,
  output logic       irq_o
);
  localparam logic [1:0] A_MASK   = 2'd0;
  localparam logic [1:0] A_RAW    = 2'd1;
  localparam logic [1:0] A_MASKED = 2'd2;

  logic [3:0] mask_q;
  logic       ovr_q, tmo_q, irq_q;
  logic [3:0] raw, masked;

  wire mask_wr = reg_we_i && (reg_addr_i == A_MASK);
  wire clr_wr  = reg_we_i && (reg_addr_i == 2'd3);

  assign raw    = {tx_svc_i, rx_svc_i, tmo_q, ovr_q};
  assign masked = raw & mask_q;
  assign irq_o  = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ovr_q  <= 1'b0;
      tmo_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= reg_wdata_i;
      ovr_q <= rx_ovr_pulse_i | (ovr_q & ~(clr_wr & reg_wdata_i[0]));
      tmo_q <= rx_tmo_pulse_i | (tmo_q & ~(clr_wr & reg_wdata_i[1]));
      irq_q <= |masked;
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_MASK:   reg_rdata_o = mask_q;
      A_RAW:    reg_rdata_o = raw;
      A_MASKED: reg_rdata_o = masked;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ovr_evt,
  input logic       tmo_evt,
  input logic       we,
  input logic [1:0] addr,
  input logic [3:0] wdata,
  input logic       ovr_q,
  input logic       tmo_q,
  input logic [3:0] mask_q,
  input logic       irq_o
);
  wire clr0 = we && (addr == 2'd3) && wdata[0];
  wire clr1 = we && (addr == 2'd3) && wdata[1];

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_q);

  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr0) |=> ovr_q);

  a_r7_clear_tmo: assert property (@(posedge clk) disable iff (!rst_n)
    (clr1 && !tmo_evt) |=> !tmo_q);

  a_r7_clear_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr0 && !ovr_evt) |=> !ovr_q);

  a_r4_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 4'd0) |=> !irq_o);
endmodule

bind spi_irq_status spi_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .ovr_evt(rx_ovr_pulse_i), .tmo_evt(rx_tmo_pulse_i),
  .we(reg_we_i), .addr(reg_addr_i), .wdata(reg_wdata_i),
  .ovr_q(ovr_q), .tmo_q(tmo_q), .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/spi_irq_status_tb.sv
`timescale 1ns/1ps
module spi_irq_status_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_svc = 0, rx_svc = 0, tmo = 0, ovr = 0;
  logic we = 0;
  logic [1:0] addr = 0;
  logic [3:0] wdata = 0;
  logic [3:0] rdata;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_irq_status u_dut (
    .clk(clk), .rst_n(rst_n), .tx_svc_i(tx_svc), .rx_svc_i(rx_svc),
    .rx_tmo_pulse_i(tmo), .rx_ovr_pulse_i(ovr), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input string req, input logic [3:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    addr = a; wdata = d; we = 1; tick(); we = 0; wdata = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] v;
    #10; rst_n = 1; tick();
    // R1 reset state
    rd(0, "R1 mask", 4'h0);
    rd(1, "R1 raw", 4'h0);
    chk("R1 irq", {3'b0, irq}, 4'h0);

    // R2 R3 R5 sweep: every mask against every source pattern
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        tx_svc = 0; rx_svc = 0;
        wr(3, 4'h3);
        wr(0, m[3:0]);
        tx_svc = p[3]; rx_svc = p[2]; ovr = p[0]; tmo = p[1];
        tick();
        ovr = 0; tmo = 0;
        rd(1, "R2 raw", p[3:0]);
        rd(2, "R3 masked", p[3:0] & m[3:0]);
        tick();
        chk("R5 irq", {3'b0, irq}, {3'b0, |(p[3:0] & m[3:0])});
      end
    end

    // R4 mask zero keeps irq low with all sources active
    wr(0, 4'h0);
    tx_svc = 1; rx_svc = 1; ovr = 1; tmo = 1; tick(); ovr = 0; tmo = 0;
    tick(); tick();
    chk("R4 irq low", {3'b0, irq}, 4'h0);
    rd(1, "R6 flags held", 4'hF);

    // R7 zero clear has no effect; R11 clear of level bits has no effect
    wr(3, 4'h0);
    rd(1, "R7 zero clear", 4'hF);
    wr(3, 4'hC);
    rd(1, "R11 level not cleared", 4'hF);
    wr(3, 4'h1);
    rd(1, "R7 clear ovr", 4'hE);
    wr(3, 4'h2);
    rd(1, "R7 clear tmo", 4'hC);

    // R8 set beats clear in the same cycle
    ovr = 1; tmo = 1; addr = 3; wdata = 4'h3; we = 1; tick();
    we = 0; ovr = 0; tmo = 0; wdata = 0;
    rd(1, "R8 set wins", 4'hF);

    // R11 level bits follow input in the same cycle
    tx_svc = 0; rd(1, "R11 tx drop", 4'h7);
    rx_svc = 0; rd(1, "R11 rx drop", 4'h3);

    // R9 read-modify-write of mask
    wr(0, 4'h5);
    rd(0, "R9 mask load", 4'h5);
    addr = 0; #1; v = rdata | 4'h2; wr(0, v);
    rd(0, "R9 rmw set", 4'h7);
    addr = 0; #1; v = rdata & ~4'h4; wr(0, v);
    rd(0, "R9 rmw clear", 4'h3);

    // R10 writes to read-only addresses are ignored; clear reads zero
    wr(1, 4'h0);
    wr(2, 4'h0);
    rd(0, "R10 mask kept", 4'h3);
    rd(1, "R10 raw kept", 4'h3);
    rd(3, "R10 clear reads 0", 4'h0);

    // R5 irq falls one edge after the masked status empties
    tick();
    chk("R5 irq high", {3'b0, irq}, 4'h1);
    addr = 3; wdata = 4'h3; we = 1; tick(); we = 0; wdata = 0;
    chk("R5 irq lag", {3'b0, irq}, 4'h1);
    tick();
    chk("R5 irq low", {3'b0, irq}, 4'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule